// File: doc/BRIEF.md
# Staggered Bit-Group Bus Driver

This block drives a 32-bit bus segment without letting every driver switch at the same moment. A word enters through a valid/ready handshake. It is split into four bit groups by stride: group g holds every bit whose index leaves remainder g when divided by four. The groups are written onto the registered bus one after another, in slots separated by a programmable number of clock cycles. Any two neighbouring wires belong to different groups, so adjacent drivers never change in the same slot, and the peak number of simultaneous transitions falls to a quarter of the word.

Each group has a two-phase strobe that flips once each time its group is driven. A receiver section inside the block watches these strobes and captures each group as its strobe flips. Once the last group is in, it raises a one-cycle completion pulse with the reassembled word. The stagger is counted in whole clock cycles.

Top module: `stagger_bus_top`

## Requirements
- R1: `inReady` is high while no word is in flight. A word is taken on a clock edge where `inValid` and `inReady` are both high, and its group 0 reaches `busOut` on the next edge.
- R2: Group g is made of the bus bits i with i mod 4 = g. When group g is driven, exactly those bits take the accepted word's values.
- R3: Groups are driven in the order 0, 1, 2, 3. Consecutive groups are separated by G clock edges, where G is `gapCycles` sampled at acceptance, and a sampled value of 0 counts as 1. Changes to `gapCycles` during a transfer have no effect.
- R4: Bus bits outside the group being driven keep their previous value. Between group slots the whole bus holds.
- R5: `inReady` is low from the acceptance edge until the edge that drives group 3. `inValid` and `inWord` are ignored during that time.
- R6: `grpStrobe[g]` inverts on the edge that drives group g. Strobe bits of other groups hold.
- R7: On the edge after group 3 is driven, `rxWord` equals the accepted word and `wordDone` goes high for exactly one cycle.
- R8: After reset, `busOut`, `grpStrobe`, `rxWord` and `wordDone` are zero and `inReady` is high.
- R9: At most one strobe bit changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| gapCycles | input | 4 | Cycles between group slots, sampled when a word is taken |
| inValid | input | 1 | Word offered |
| inWord | input | 32 | Offered word |
| inReady | output | 1 | Block can take a word |
| busOut | output | 32 | Registered bus segment drivers |
| grpStrobe | output | 4 | Two-phase strobe per bit group |
| rxWord | output | 32 | Word reassembled by the receiver |
| wordDone | output | 1 | One-cycle pulse when reassembly completes |

## Verification
Two functions can fall in the same cycle. The receiver captures group 3 and raises `wordDone` on the same edge on which the transmitter, ready again, takes the next word. The bench provokes this by presenting the next word in the cycle right after group 3 is driven. It then checks that the completion pulse carries the old word while `inReady` has already dropped for the new one. The new word's group 0 must also appear exactly one edge later. Random words and gaps are mixed with gap 0, gap 15, and words offered in mid-transfer with a changed gap. All of these are judged against a bench model of the bus contents.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
  localparam int WORD_W    = 32;
  localparam int GROUPS    = 4;
  localparam int GRP_IDX_W = $clog2(GROUPS);
  localparam int GAP_W     = 4;

  typedef struct packed {
    logic                 loadWord;
    logic                 driveGroup;
    logic [GRP_IDX_W-1:0] grpSel;
  } ctrl_t;
endpackage

// File: rtl/stagger_ctrl.sv
module stagger_ctrl
  import stagger_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             inValid,
  output logic             inReady,
  output ctrl_t            ctrl
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t               state;
  logic [GAP_W-1:0]     gapReg;
  logic [GAP_W-1:0]     waitCnt;
  logic [GRP_IDX_W-1:0] grpIdx;
  logic                 accept;
  logic                 fire;
  logic                 lastGrp;

  assign inReady = (state == ST_IDLE);
  assign accept  = inValid && inReady;
  assign fire    = (state == ST_SEND) && (waitCnt == '0);
  assign lastGrp = (grpIdx == GRP_IDX_W'(GROUPS - 1));

  always_comb begin
    ctrl.loadWord   = accept;
    ctrl.driveGroup = fire;
    ctrl.grpSel     = grpIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gapReg  <= GAP_W'(1);
      waitCnt <= '0;
      grpIdx  <= '0;
    end else begin
      if (accept) begin
        state   <= ST_SEND;
        gapReg  <= (gapCycles == '0) ? GAP_W'(1) : gapCycles;
        waitCnt <= '0;
        grpIdx  <= '0;
      end else if (fire) begin
        waitCnt <= gapReg - GAP_W'(1);
        if (lastGrp) begin
          state  <= ST_IDLE;
          grpIdx <= '0;
        end else begin
          grpIdx <= grpIdx + GRP_IDX_W'(1);
        end
      end else if (state == ST_SEND) begin
        waitCnt <= waitCnt - GAP_W'(1);
      end
    end
  end
endmodule

// File: rtl/stagger_dpath.sv
module stagger_dpath
  import stagger_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] busOut,
  output logic [GROUPS-1:0] grpStrobe
);
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] nxtBus;
  logic [GROUPS-1:0] nxtStrobe;

  always_comb begin
    nxtBus = busOut;
    for (int b = 0; b < WORD_W; b++) begin
      if (ctrl.driveGroup && (GRP_IDX_W'(b % GROUPS) == ctrl.grpSel))
        nxtBus[b] = wordReg[b];
    end
  end

  always_comb begin
    nxtStrobe = grpStrobe;
    for (int g = 0; g < GROUPS; g++) begin
      if (ctrl.driveGroup && (GRP_IDX_W'(g) == ctrl.grpSel))
        nxtStrobe[g] = ~grpStrobe[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg   <= '0;
      busOut    <= '0;
      grpStrobe <= '0;
    end else begin
      if (ctrl.loadWord) wordReg <= inWord;
      busOut    <= nxtBus;
      grpStrobe <= nxtStrobe;
    end
  end
endmodule

// File: rtl/stagger_rx.sv
module stagger_rx
  import stagger_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] busIn,
  input  logic [GROUPS-1:0] strobeIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              wordDone
);
  logic [GROUPS-1:0] prevStrobe;
  logic [GROUPS-1:0] flipped;
  logic [WORD_W-1:0] nxtWord;

  assign flipped = strobeIn ^ prevStrobe;

  always_comb begin
    nxtWord = rxWord;
    for (int b = 0; b < WORD_W; b++) begin
      if (flipped[b % GROUPS]) nxtWord[b] = busIn[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStrobe <= '0;
      rxWord     <= '0;
      wordDone   <= 1'b0;
    end else begin
      prevStrobe <= strobeIn;
      rxWord     <= nxtWord;
      wordDone   <= flipped[GROUPS-1];
    end
  end
endmodule

// File: rtl/stagger_bus_top.sv
module stagger_bus_top
  import stagger_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [GAP_W-1:0]  gapCycles,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic [WORD_W-1:0] busOut,
  output logic [GROUPS-1:0] grpStrobe,
  output logic [WORD_W-1:0] rxWord,
  output logic              wordDone
);
  ctrl_t ctrl;

  stagger_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .gapCycles(gapCycles),
    .inValid(inValid), .inReady(inReady), .ctrl(ctrl)
  );

  stagger_dpath i_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inWord(inWord),
    .busOut(busOut), .grpStrobe(grpStrobe)
  );

  stagger_rx i_rx (
    .clk(clk), .rstN(rstN), .busIn(busOut), .strobeIn(grpStrobe),
    .rxWord(rxWord), .wordDone(wordDone)
  );
endmodule

// File: rtl/stagger_bus_chk.sv
module stagger_bus_chk
  import stagger_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [GAP_W-1:0]  gapCycles,
  input logic              inValid,
  input logic [WORD_W-1:0] inWord,
  input logic              inReady,
  input logic [WORD_W-1:0] busOut,
  input logic [GROUPS-1:0] grpStrobe,
  input logic [WORD_W-1:0] rxWord,
  input logic              wordDone
);
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grpStrobe ^ $past(grpStrobe)) <= 1);

  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grpStrobe == $past(grpStrobe)) |-> (busOut == $past(busOut)));

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> !wordDone);

  p_done_after_g3_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordDone) |-> ($past(grpStrobe[GROUPS-1], 1) != $past(grpStrobe[GROUPS-1], 2)));

  p_no_strobe_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !$past(inReady) && !(inValid && inReady)) |=> $stable(grpStrobe));
endmodule

bind stagger_bus_top stagger_bus_chk i_chk (.*);

// File: tb/test_stagger_bus_top.sv
module test_stagger_bus_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  gapCycles = 4'd1;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inReady;
  logic [31:0] busOut;
  logic [3:0]  grpStrobe;
  logic [31:0] rxWord;
  logic        wordDone;

  int total = 0;
  int bad = 0;
  logic [31:0] modelBus = '0;
  logic [3:0]  modelStrobe = '0;
  bit preLoaded = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stagger_bus_top i_stagger_bus_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] groupMask(input int g);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) if (b % 4 == g) m[b] = 1'b1;
    return m;
  endfunction

  task automatic finishRun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Runs one word. junk: offer another word and gap in mid-transfer.
  // chain: offer the next word right after group 3 is driven.
  task automatic runWord(input logic [31:0] word, input logic [3:0] gap, input bit junk,
                         input bit chain, input logic [31:0] nxtWord, input logic [3:0] nxtGap);
    int effGap = (gap == 0) ? 1 : int'(gap);
    if (!preLoaded) begin
      @(negedge clk);
      check("R1 ready idle", {31'd0, inReady}, 32'd1);
      inValid = 1'b1; inWord = word; gapCycles = gap;
      @(negedge clk);
      inValid = 1'b0;
    end
    check("R5 ready low after accept", {31'd0, inReady}, 32'd0);
    if (junk) begin
      inValid = 1'b1; inWord = ~word; gapCycles = 4'd15 - gap;
    end
    for (int k = 0; k < 4; k++) begin
      int waits = (k == 0) ? 1 : effGap;
      for (int w = 0; w < waits - 1; w++) begin
        @(negedge clk);
        check("R4 bus holds between slots", busOut, modelBus);
        check("R3 no early strobe", {28'd0, grpStrobe}, {28'd0, modelStrobe});
      end
      @(negedge clk);
      modelBus = (modelBus & ~groupMask(k)) | (word & groupMask(k));
      modelStrobe[k] = ~modelStrobe[k];
      check($sformatf("R2 group %0d bits", k), busOut, modelBus);
      check($sformatf("R6 strobe %0d", k), {28'd0, grpStrobe}, {28'd0, modelStrobe});
      if (k < 3) check("R5 ready low in flight", {31'd0, inReady}, 32'd0);
      else begin
        check("R5 ready back after group 3", {31'd0, inReady}, 32'd1);
        inValid = 1'b0;
        if (chain) begin
          inValid = 1'b1; inWord = nxtWord; gapCycles = nxtGap;
        end
      end
    end
    @(negedge clk);
    check("R7 done pulse", {31'd0, wordDone}, 32'd1);
    check("R7 reassembled word", rxWord, word);
    inValid = 1'b0;
    preLoaded = chain;
    if (chain) begin
      check("R1 chained word taken", {31'd0, inReady}, 32'd0);
    end else begin
      @(negedge clk);
      check("R7 done one cycle", {31'd0, wordDone}, 32'd0);
      check("R4 bus idle hold", busOut, modelBus);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 bus reset", busOut, 32'd0);
    check("R8 strobe reset", {28'd0, grpStrobe}, 32'd0);
    check("R8 rx reset", rxWord, 32'd0);
    check("R8 done reset", {31'd0, wordDone}, 32'd0);
    check("R8 ready reset", {31'd0, inReady}, 32'd1);

    runWord(32'hFFFF_FFFF, 4'd1, 0, 0, '0, '0);
    runWord(32'h0000_0000, 4'd0, 0, 0, '0, '0);     // R3 gap zero acts as one
    runWord(32'hA5A5_5A5A, 4'd15, 0, 0, '0, '0);
    runWord(32'h1234_5678, 4'd3, 1, 0, '0, '0);     // R5 junk offer, R3 gap change ignored
    runWord(32'hDEAD_BEEF, 4'd2, 0, 1, 32'hCAFE_F00D, 4'd4);
    runWord(32'hCAFE_F00D, 4'd4, 0, 1, 32'h0F0F_0F0F, 4'd1);
    runWord(32'h0F0F_0F0F, 4'd1, 0, 0, '0, '0);
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w = $urandom;
      logic [3:0]  g = 4'($urandom_range(0, 15));
      bit jk = ($urandom_range(0, 3) == 0);
      runWord(w, g, jk, 0, '0, '0);
    end
    finishRun();
  end
endmodule